// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block collects a parameterised set of shared interrupt lines, keeps the per-line configuration and run-time state for them, and nominates one interrupt at a time to a processor-side interface. Software configures it through a plain 32-bit register bus. Each line has an enable bit, a group bit, an 8-bit priority and a trigger mode. Enables are set and cleared through separate write-one banks. Pending state is latched on a rising edge or follows the input level, depending on the trigger mode.

Every cycle the block scans all lines that are eligible: pending, enabled, not already in service, and belonging to a group that the control register has switched on. It registers the winner's ID and priority for the processor side. A numerically smaller priority wins, and among equal priorities the smallest ID wins. The processor side acknowledges an ID, which marks it active and drops an edge-latched pending bit. It later signals end of service, which releases the active mark. IDs 0 to 31 belong to per-core logic elsewhere and are inert here. With the default configuration there are 64 IDs, and 32 to 63 are live.

Top module: `irq_distributor`

## Requirements
- R1: After reset, all enable, group, priority, trigger and pending state is zero, `pick_valid` is 0 and `pick_id` is 1023.
- R2: A read at 0x004 returns NUM_IRQ/32-1 in bits [4:0] and zero elsewhere.
- R3: Offset 0x000 stores bit 0 (group 0 enable), bit 1 (group 1 enable) and bit 5 (routing enable, stored only), and other written bits read 0. Bit 31 reads 1 for every read accepted in the 4 cycles after a write to 0x000, and 0 after that.
- R4: A write to 0x100+4*(id/32) with bit id%32 set enables that ID. A write to 0x180+4*(id/32) with that bit set disables it. Zero bits change nothing. Reads of either offset return the current enable bits.
- R5: For IDs below 32, writes are ignored, every field reads 0, and the ID is never pending or picked.
- R6: With bit 2*(id%16)+1 of 0xC00+4*(id/16) set, the ID is edge-triggered. A rising input edge makes it pending, and it stays pending after the input falls. It is cleared by writing 1 to bit id%32 of 0x280+4*(id/32), or by an acknowledge of that ID. Reads of 0x280 return the pending bits, and field bit 0 of the trigger word always reads 0.
- R7: With that trigger bit at 0, the ID is level-sensitive. Its pending bit follows the input one cycle late, and a clear-pending write has no effect while the input is high.
- R8: The priority of an ID sits in byte lane id%4 of 0x400+4*(id/4). The lowest priority value wins, and ties go to the lowest ID. `pick_prio` carries the winner's priority.
- R9: An ID is eligible only when it is pending, enabled and not active, and its group is enabled. The group bit is at 0x080+4*(id/32), bit id%32: 1 selects group 1 (control bit 1) and 0 selects group 0 (control bit 0). With nothing eligible, `pick_valid` is 0 and `pick_id` is 1023.
- R10: `ack_valid` with a live `ack_id` marks that ID active and clears its edge-pending bit. `eoi_valid` with `eoi_id` clears the active mark.
- R11: When a rising edge and a clear-pending write for the same edge-mode ID fall in the same cycle, the ID remains pending.
- R12: Read data appears on `bus_rdata` with `bus_rvalid` one cycle after the request. The pick outputs reflect the state one cycle after that state changes, so a level input reaches the pick two cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq_lines | input | NUM_IRQ | Interrupt inputs, indexed by ID |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 10 | Acknowledged ID |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | 10 | ID whose service ended |
| pick_valid | output | 1 | A nominated interrupt is present |
| pick_id | output | 10 | Nominated ID, 1023 when none |
| pick_prio | output | 8 | Priority of the nominated ID |

## Verification
The latching of a new rising edge and a software clear of the same pending bit can land on the same clock edge. The bench first leaves an edge-mode ID pending with its input low. On one cycle it then raises the input and writes the clear bit for that ID. It judges the result by reading the pending bank and the pick outputs afterwards, where the bit must still be set. The bench also drives an acknowledge while the level input of the same ID stays high. It expects the ID to leave the pick through the active mark and not through its pending state.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int FIRST_SHARED = 32;
  localparam int NO_IRQ_ID    = 1023;
  localparam int ID_W         = 10;
  localparam int PRIO_W       = 8;
  localparam int BUS_AW       = 12;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_CTRL,
    RS_TYPE,
    RS_GROUP,
    RS_SETEN,
    RS_CLREN,
    RS_CLRPEND,
    RS_PRIO,
    RS_TRIG
  } reg_sel_e;

  typedef struct packed {
    logic             valid;
    logic [ID_W-1:0]  id;
    logic [PRIO_W-1:0] prio;
  } pick_t;
endpackage

// File: rtl/dist_ctrl.sv
module dist_ctrl #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic        grp0_on,
  output logic        grp1_on,
  output logic        route_on,
  output logic        busy
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp0_on    <= 1'b0;
      grp1_on    <= 1'b0;
      route_on   <= 1'b0;
      settle_cnt <= '0;
    end else if (wr_en) begin
      grp0_on    <= wdata[0];
      grp1_on    <= wdata[1];
      route_on   <= wdata[5];
      settle_cnt <= CW'(SETTLE_CYCLES);
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  assign busy = (settle_cnt != '0);
endmodule

// File: rtl/dist_line_state.sv
module dist_line_state
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] lines,
  input  logic [NUM_IRQ-1:0] edge_mode,
  input  logic [NUM_IRQ-1:0] clr_pend,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               eoi_valid,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] active
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i < FIRST_SHARED) begin : g_private
      assign pending[i] = 1'b0;
      assign active[i]  = 1'b0;
    end else begin : g_shared
      logic in_q;
      logic latch_q;
      logic act_q;
      logic rise;
      logic acked;
      logic ended;

      assign rise  = lines[i] & ~in_q;
      assign acked = ack_valid && (ack_id == ID_W'(i));
      assign ended = eoi_valid && (eoi_id == ID_W'(i));

      always_ff @(posedge clk) begin
        if (rst) begin
          in_q    <= 1'b0;
          latch_q <= 1'b0;
          act_q   <= 1'b0;
        end else begin
          in_q <= lines[i];
          if (!edge_mode[i])
            latch_q <= 1'b0;
          else if (rise)
            latch_q <= 1'b1;
          else if (clr_pend[i] || acked)
            latch_q <= 1'b0;
          if (acked)
            act_q <= 1'b1;
          else if (ended)
            act_q <= 1'b0;
        end
      end

      assign pending[i] = edge_mode[i] ? latch_q : in_q;
      assign active[i]  = act_q;
    end
  end
endmodule

// File: rtl/dist_arbiter.sv
module dist_arbiter
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_IRQ-1:0]            eligible,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
  output pick_t                         pick
);
  pick_t best;

  always_comb begin
    best.valid = 1'b0;
    best.id    = ID_W'(NO_IRQ_ID);
    best.prio  = '0;
    for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
      if (eligible[i] && (!best.valid || prio[i] < best.prio)) begin
        best.valid = 1'b1;
        best.id    = ID_W'(i);
        best.prio  = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pick.valid <= 1'b0;
      pick.id    <= ID_W'(NO_IRQ_ID);
      pick.prio  <= '0;
    end else begin
      pick <= best;
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ       = 64,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               ack_valid,
  input  logic [9:0]         ack_id,
  input  logic               eoi_valid,
  input  logic [9:0]         eoi_id,
  output logic               pick_valid,
  output logic [9:0]         pick_id,
  output logic [7:0]         pick_prio
);
  localparam int LINE_GROUPS = NUM_IRQ / 32;
  localparam logic [4:0] TYPE_N = 5'(LINE_GROUPS - 1);

  reg_sel_e   sel;
  logic [7:0] widx;
  logic       wr;

  logic [NUM_IRQ-1:0]             en_bits;
  logic [NUM_IRQ-1:0]             grp_bits;
  logic [NUM_IRQ-1:0]             edge_bits;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_tab;
  logic [NUM_IRQ-1:0]             clr_mask;
  logic [NUM_IRQ-1:0]             pend_bits;
  logic [NUM_IRQ-1:0]             active_bits;
  logic [NUM_IRQ-1:0]             eligible;

  logic  grp0_on, grp1_on, route_on, rwp_busy;
  pick_t pick;
  logic [31:0] rd_word;

  // Address decode: bank and word index inside the bank
  always_comb begin
    sel  = RS_NONE;
    widx = '0;
    if (bus_addr == 12'h000)
      sel = RS_CTRL;
    else if (bus_addr == 12'h004)
      sel = RS_TYPE;
    else if (bus_addr[11:7] == 5'b00001) begin
      sel = RS_GROUP;   widx = {3'b0, bus_addr[6:2]};
    end else if (bus_addr[11:7] == 5'b00010) begin
      sel = RS_SETEN;   widx = {3'b0, bus_addr[6:2]};
    end else if (bus_addr[11:7] == 5'b00011) begin
      sel = RS_CLREN;   widx = {3'b0, bus_addr[6:2]};
    end else if (bus_addr[11:7] == 5'b00101) begin
      sel = RS_CLRPEND; widx = {3'b0, bus_addr[6:2]};
    end else if (bus_addr[11:10] == 2'b01) begin
      sel = RS_PRIO;    widx = bus_addr[9:2];
    end else if (bus_addr[11:8] == 4'hC) begin
      sel = RS_TRIG;    widx = {2'b0, bus_addr[7:2]};
    end
  end

  assign wr = bus_req && bus_we;

  dist_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr && sel == RS_CTRL),
    .wdata    (bus_wdata),
    .grp0_on  (grp0_on),
    .grp1_on  (grp1_on),
    .route_on (route_on),
    .busy     (rwp_busy)
  );

  // Per-line configuration storage; private IDs keep their reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      en_bits   <= '0;
      grp_bits  <= '0;
      edge_bits <= '0;
      prio_tab  <= '0;
    end else if (wr) begin
      for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
        if (sel == RS_SETEN && widx == 8'(i / 32) && bus_wdata[i % 32])
          en_bits[i] <= 1'b1;
        if (sel == RS_CLREN && widx == 8'(i / 32) && bus_wdata[i % 32])
          en_bits[i] <= 1'b0;
        if (sel == RS_GROUP && widx == 8'(i / 32))
          grp_bits[i] <= bus_wdata[i % 32];
        if (sel == RS_PRIO && widx == 8'(i / 4))
          prio_tab[i] <= bus_wdata[8*(i % 4) +: 8];
        if (sel == RS_TRIG && widx == 8'(i / 16))
          edge_bits[i] <= bus_wdata[2*(i % 16) + 1];
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int i = FIRST_SHARED; i < NUM_IRQ; i++)
      clr_mask[i] = wr && sel == RS_CLRPEND && widx == 8'(i / 32) && bus_wdata[i % 32];
  end

  dist_line_state #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .lines     (irq_lines),
    .edge_mode (edge_bits),
    .clr_pend  (clr_mask),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .eoi_valid (eoi_valid),
    .eoi_id    (eoi_id),
    .pending   (pend_bits),
    .active    (active_bits)
  );

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      eligible[i] = pend_bits[i] && en_bits[i] && !active_bits[i] &&
                    (grp_bits[i] ? grp1_on : grp0_on);
  end

  dist_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .eligible (eligible),
    .prio     (prio_tab),
    .pick     (pick)
  );

  assign pick_valid = pick.valid;
  assign pick_id    = pick.id;
  assign pick_prio  = pick.prio;

  // Read multiplexer
  always_comb begin
    rd_word = '0;
    case (sel)
      RS_CTRL: rd_word = {rwp_busy, 25'b0, route_on, 3'b0, grp1_on, grp0_on};
      RS_TYPE: rd_word = {27'b0, TYPE_N};
      default: begin
        for (int i = FIRST_SHARED; i < NUM_IRQ; i++) begin
          if (sel == RS_GROUP && widx == 8'(i / 32))
            rd_word[i % 32] = grp_bits[i];
          if ((sel == RS_SETEN || sel == RS_CLREN) && widx == 8'(i / 32))
            rd_word[i % 32] = en_bits[i];
          if (sel == RS_CLRPEND && widx == 8'(i / 32))
            rd_word[i % 32] = pend_bits[i];
          if (sel == RS_PRIO && widx == 8'(i / 4))
            rd_word[8*(i % 4) +: 8] = prio_tab[i];
          if (sel == RS_TRIG && widx == 8'(i / 16))
            rd_word[2*(i % 16) + 1] = edge_bits[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we)
        bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_we,
  input logic [11:0]        bus_addr,
  input logic               pick_valid,
  input logic [9:0]         pick_id,
  input logic               ack_valid,
  input logic [9:0]         ack_id,
  input logic               rwp_busy,
  input logic [NUM_IRQ-1:0] en_bits,
  input logic [NUM_IRQ-1:0] pend_bits,
  input logic [NUM_IRQ-1:0] active_bits
);
  localparam int IW = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] en_q, pend_q, act_q;
  logic [IW-1:0]      last_ack;
  logic               ack_live;

  assign ack_live = ack_valid && ack_id >= 10'd32 && ack_id < 10'(NUM_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      last_ack <= '0;
    end else begin
      en_q     <= en_bits;
      pend_q   <= pend_bits;
      act_q    <= active_bits;
      last_ack <= ack_id[IW-1:0];
    end
  end

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pick_valid && pick_id == 10'd1023));

  // R3
  a_r3_rwp_after_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == 12'h000) |=> rwp_busy);

  // R5
  a_r5_pick_in_shared_range: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> (pick_id >= 10'd32 && pick_id < 10'(NUM_IRQ)));

  // R9
  a_r9_pick_was_eligible: assert property (@(posedge clk) disable iff (rst)
    (pick_valid && !$past(rst)) |->
      (en_q[pick_id[IW-1:0]] && pend_q[pick_id[IW-1:0]] && !act_q[pick_id[IW-1:0]]));

  // R10
  a_r10_ack_marks_active: assert property (@(posedge clk) disable iff (rst)
    ack_live |=> active_bits[last_ack]);
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .pick_valid  (pick_valid),
  .pick_id     (pick_id),
  .ack_valid   (ack_valid),
  .ack_id      (ack_id),
  .rwp_busy    (rwp_busy),
  .en_bits     (en_bits),
  .pend_bits   (pend_bits),
  .active_bits (active_bits)
);

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
  localparam int NUM_IRQ = 64;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_req = 1'b0;
  logic               bus_we = 1'b0;
  logic [11:0]        bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               bus_rvalid;
  logic [NUM_IRQ-1:0] irq_lines = '0;
  logic               ack_valid = 1'b0;
  logic [9:0]         ack_id = '0;
  logic               eoi_valid = 1'b0;
  logic [9:0]         eoi_id = '0;
  logic               pick_valid;
  logic [9:0]         pick_id;
  logic [7:0]         pick_prio;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_IRQ(NUM_IRQ)) i_irq_distributor (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_lines(irq_lines), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .pick_valid(pick_valid),
    .pick_id(pick_id), .pick_prio(pick_prio)
  );

  function automatic logic [7:0] pf(int id);
    return 8'((((id * 5) % 4) * 64) + 8);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdw(logic [11:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pick(string req, logic v, int id, logic [7:0] p);
    chk(req, {22'b0, pick_valid, pick_id}, {22'b0, v, 10'(id)});
    if (v) chk(req, {24'b0, pick_prio}, {24'b0, p});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk_pick("R1", 1'b0, 1023, 8'd0);
    for (int w = 0; w < 2; w++) begin
      rdw(12'h100 + 12'(4*w), rd); chk("R1", rd, 32'h0);
      rdw(12'h280 + 12'(4*w), rd); chk("R1", rd, 32'h0);
    end
    rdw(12'h000, rd); chk("R1", rd, 32'h0);
    // R2 type register
    rdw(12'h004, rd); chk("R2", rd, 32'(NUM_IRQ/32 - 1));
    // R3 control and write-pending window, R12 read latency
    wr(12'h000, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) begin
      rdw(12'h000, rd);
      chk("R3", rd, (k < 4) ? 32'h8000_0023 : 32'h0000_0023);
      chk("R12", {31'b0, bus_rvalid}, 32'h1);
    end
    // R4/R5 enable sweep
    for (int id = 0; id < NUM_IRQ; id++) begin
      wr(12'h100 + 12'(4*(id/32)), 32'h1 << (id % 32));
      rdw(12'h180 + 12'(4*(id/32)), rd);
      if (id < 32) chk("R5", rd, 32'h0);
      else chk("R4", rd, (id == 63) ? 32'hFFFF_FFFF : ((32'h1 << (id % 32 + 1)) - 1));
    end
    wr(12'h180 + 12'h4, 32'h5555_5555);
    wr(12'h180 + 12'h4, 32'h0);
    rdw(12'h104, rd); chk("R4", rd, 32'hAAAA_AAAA);
    wr(12'h100 + 12'h4, 32'hFFFF_FFFF);
    // R8/R5 priority sweep
    for (int w = 0; w < NUM_IRQ/4; w++)
      wr(12'h400 + 12'(4*w), {pf(4*w+3), pf(4*w+2), pf(4*w+1), pf(4*w)});
    for (int w = 0; w < NUM_IRQ/4; w++) begin
      rdw(12'h400 + 12'(4*w), rd);
      if (w < 8) chk("R5", rd, 32'h0);
      else chk("R8", rd, {pf(4*w+3), pf(4*w+2), pf(4*w+1), pf(4*w)});
    end
    // R6 trigger field readback
    for (int w = 0; w < NUM_IRQ/16; w++) wr(12'hC00 + 12'(4*w), 32'hFFFF_FFFF);
    for (int w = 0; w < NUM_IRQ/16; w++) begin
      rdw(12'hC00 + 12'(4*w), rd);
      chk(w < 2 ? "R5" : "R6", rd, w < 2 ? 32'h0 : 32'hAAAA_AAAA);
    end
    for (int w = 0; w < NUM_IRQ/16; w++) wr(12'hC00 + 12'(4*w), 32'h0);
    wr(12'h000, 32'h3);
    // R5 private lines never pending
    irq_lines[31:0] = '1;
    step(3);
    rdw(12'h280, rd); chk("R5", rd, 32'h0);
    chk_pick("R5", 1'b0, 1023, 8'd0);
    irq_lines = '0;
    // R8 single-line sweep and multi-line patterns (level mode)
    for (int t = 0; t < 52; t++) begin
      logic [31:0] m;
      int best;
      m = (t < 32) ? (32'h1 << t) : 32'((t - 31) * 32'h9E37_79B1);
      irq_lines = {m, 32'h0};
      step(3);
      best = -1;
      for (int j = 0; j < 32; j++)
        if (m[j] && (best < 0 || pf(32+j) < pf(best))) best = 32 + j;
      chk_pick("R8", best >= 0, best < 0 ? 1023 : best, best < 0 ? 8'd0 : pf(best));
    end
    irq_lines = '0;
    step(3);
    chk_pick("R9", 1'b0, 1023, 8'd0);
    // R7 level: clear-pending ignored while high
    irq_lines[45] = 1'b1;
    step(3);
    wr(12'h284, 32'h1 << 13);
    rdw(12'h284, rd); chk("R7", rd, 32'h1 << 13);
    irq_lines[45] = 1'b0;
    step(2);
    rdw(12'h284, rd); chk("R7", rd, 32'h0);
    // R6 edge latch
    wr(12'hC08, 32'h2 << (2*(40 % 16)) | 32'h2 << (2*(41 % 16)));
    irq_lines[40] = 1'b1; step(1); irq_lines[40] = 1'b0; step(2);
    rdw(12'h284, rd); chk("R6", rd, 32'h1 << 8);
    chk_pick("R6", 1'b1, 40, pf(40));
    wr(12'h284, 32'h1 << 8); step(1);
    rdw(12'h284, rd); chk("R6", rd, 32'h0);
    chk_pick("R6", 1'b0, 1023, 8'd0);
    // R10 ack clears edge pending, marks active; eoi releases
    irq_lines[40] = 1'b1; step(1); irq_lines[40] = 1'b0; step(2);
    ack_valid = 1'b1; ack_id = 10'd40; step(1); ack_valid = 1'b0;
    rdw(12'h284, rd); chk("R10", rd, 32'h0);
    eoi_valid = 1'b1; eoi_id = 10'd40; step(1); eoi_valid = 1'b0;
    irq_lines[45] = 1'b1; step(3);
    chk_pick("R10", 1'b1, 45, pf(45));
    ack_valid = 1'b1; ack_id = 10'd45; step(1); ack_valid = 1'b0;
    step(1);
    chk_pick("R10", 1'b0, 1023, 8'd0);
    rdw(12'h284, rd); chk("R10", rd, 32'h1 << 13);
    eoi_valid = 1'b1; eoi_id = 10'd45; step(1); eoi_valid = 1'b0;
    step(1);
    chk_pick("R10", 1'b1, 45, pf(45));
    irq_lines[45] = 1'b0; step(3);
    // R9 group gating and enable gating
    wr(12'h084, 32'h1 << 18);
    rdw(12'h084, rd); chk("R9", rd, 32'h1 << 18);
    wr(12'h000, 32'h1);
    irq_lines[50] = 1'b1; step(3);
    chk_pick("R9", 1'b0, 1023, 8'd0);
    wr(12'h000, 32'h2); step(1);
    chk_pick("R9", 1'b1, 50, pf(50));
    wr(12'h184, 32'h1 << 18); step(1);
    chk_pick("R9", 1'b0, 1023, 8'd0);
    irq_lines[50] = 1'b0; wr(12'h000, 32'h3); step(3);
    // R11 rising edge and clear-pending on the same edge
    irq_lines[41] = 1'b1; step(1); irq_lines[41] = 1'b0; step(2);
    irq_lines[41] = 1'b1;
    wr(12'h284, 32'h1 << 9);
    step(1);
    rdw(12'h284, rd); chk("R11", rd, 32'h1 << 9);
    chk_pick("R11", 1'b1, 41, pf(41));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule